// File: doc/BRIEF.md
# Two-Read One-Write Register Array

A synchronous storage array with one write port and two read ports that operate independently of each other. Every port presents an enable and an address, and the write port also presents a data word. All of these inputs are captured in staging registers on the rising clock edge before they reach the storage. The write takes effect on the edge that follows its staging. Each read port looks up its staged address and captures the result in an output register, so read data appears two cycles after the request.

The array is meant as a small register-file macro inside a larger pipeline. Depth and word width are parameters. The default is 64 words of 72 bits; 32 words of 32 bits is the other intended setting. The address width follows from the depth.

A read and a write that target the same entry in the same cycle are never issued by the surrounding logic, so the result of that case is left open.

Top module: `regfile_2r1w`

## Requirements
- R1: The two read ports are independent. In the same cycle they return the contents of two different entries, or of the same entry, with no interference between them.
- R2: `DEPTH` and `WIDTH` set the size of the array, and the address width is `$clog2(DEPTH)`: 6 bits at the default 64x72 and 5 bits at 32x32. Entry 0 and entry `DEPTH-1` are both reachable.
- R3: The data for a read request presented in cycle N is on the read data output in cycle N+2. It must be sampled before the rising edge that ends cycle N+2.
- R4: A write presented in cycle N is returned by a read of that entry presented in cycle N+1 or in any later cycle.
- R5: Reset is synchronous and active high.
  - While reset is asserted, the staged enables are cleared, so a write or read presented during reset has no effect.
  - Both read data outputs are zero from the first reset edge until a read completes after reset.
- R6: A read data output holds its last value in every cycle whose matching request, two cycles earlier, had its enable low. This is true even if the entry it came from has been rewritten since.
- R7: Only the address present at the clock edge that ends the request cycle is used. A change on the address inputs after that edge does not alter the read result.
- R8: When the write enable is low, the write address and write data have no effect on the array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_en | input | 1 | Read port 0 request enable |
| rd0_addr | input | AW | Read port 0 entry address |
| rd0_data | output | WIDTH | Read port 0 data, two cycles after the request |
| rd1_en | input | 1 | Read port 1 request enable |
| rd1_addr | input | AW | Read port 1 entry address |
| rd1_data | output | WIDTH | Read port 1 data, two cycles after the request |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | AW | Write port entry address |
| wr_data | input | WIDTH | Write port data word |

## Verification
The most delicate overlap is a write landing in the array on the same edge at which a read to that entry, presented one cycle after the write, is staged. The bench provokes this by writing an entry and reading it on both ports in the very next cycle, and again at random throughout a long mixed run. The behavioural model applies each write only after the reads of its own cycle have been looked up. Any read issued a cycle later must therefore return the new word, and a stale value is reported against R4. A second overlap is a rewrite of an entry while a disabled port should still hold that entry's old value. This is judged against R6.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Address bits needed to reach every entry of the array.
  function automatic int rf_addr_width(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // Output register update rule: take the new word on a request, else hold.
  function automatic logic [1023:0] rf_pick(input logic take,
                                            input logic [1023:0] fresh,
                                            input logic [1023:0] held);
    return take ? fresh : held;
  endfunction

endpackage

// File: rtl/rf_stage.sv
module rf_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [PW-1:0] pay_i,
  output logic          en_q,
  output logic [PW-1:0] pay_q
);

  // Only the enable is cleared by reset; the payload is don't-care while idle.
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  always_ff @(posedge clk) begin
    pay_q <= pay_i;
  end

  // R5: first cycle out of reset never carries a staged request
  a_r5_stage_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !en_q);

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 72,
  parameter int NRD   = 2,
  localparam int AW   = rf_pkg::rf_addr_width(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rword
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             wr_fire;

  assign wr_fire = we;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rword[g] = mem[raddr[g]];
  end

  // R4: a staged write is present in the array on the following cycle
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int WIDTH = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_q,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] data
);

  logic [1023:0] next_wide;
  logic          take_word;

  assign take_word = req_q;
  assign next_wide = rf_pkg::rf_pick(take_word, 1024'(word), 1024'(data));

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= next_wide[WIDTH-1:0];
  end

  // R6: no staged request means the output register keeps its value
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_q |=> $stable(data));

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 72,
  localparam int AW   = rf_pkg::rf_addr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd0_en,
  input  logic [AW-1:0]    rd0_addr,
  output logic [WIDTH-1:0] rd0_data,
  input  logic             rd1_en,
  input  logic [AW-1:0]    rd1_addr,
  output logic [WIDTH-1:0] rd1_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);

  localparam int NRD = 2;

  logic [NRD-1:0]            rd_en_v;
  logic [NRD-1:0][AW-1:0]    rd_addr_v;
  logic [NRD-1:0][WIDTH-1:0] rd_data_v;
  logic [NRD-1:0]            stg_rd_en;
  logic [NRD-1:0][AW-1:0]    stg_rd_addr;
  logic [NRD-1:0][WIDTH-1:0] arr_word;

  logic                      stg_wr_en;
  logic [AW+WIDTH-1:0]       stg_wr_pay;
  logic [AW-1:0]             stg_wr_addr;
  logic [WIDTH-1:0]          stg_wr_data;

  assign rd_en_v   = {rd1_en, rd0_en};
  assign rd_addr_v = {rd1_addr, rd0_addr};
  assign rd0_data  = rd_data_v[0];
  assign rd1_data  = rd_data_v[1];

  // Write side: enable, address and data staged together.
  rf_stage #(.PW(AW + WIDTH)) u_wr_stage (
    .clk   (clk),
    .rst   (rst),
    .en_i  (wr_en),
    .pay_i ({wr_addr, wr_data}),
    .en_q  (stg_wr_en),
    .pay_q (stg_wr_pay)
  );

  assign stg_wr_addr = stg_wr_pay[AW+WIDTH-1:WIDTH];
  assign stg_wr_data = stg_wr_pay[WIDTH-1:0];

  rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (stg_wr_en),
    .waddr (stg_wr_addr),
    .wdata (stg_wr_data),
    .raddr (stg_rd_addr),
    .rword (arr_word)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_rport
    rf_stage #(.PW(AW)) u_rd_stage (
      .clk   (clk),
      .rst   (rst),
      .en_i  (rd_en_v[g]),
      .pay_i (rd_addr_v[g]),
      .en_q  (stg_rd_en[g]),
      .pay_q (stg_rd_addr[g])
    );

    rf_read_port #(.WIDTH(WIDTH)) u_out (
      .clk   (clk),
      .rst   (rst),
      .req_q (stg_rd_en[g]),
      .word  (arr_word[g]),
      .data  (rd_data_v[g])
    );

    // R3: output only moves two cycles after an enabled request
    a_r3_change_needs_request: assert property (@(posedge clk) disable iff (rst)
      (rd_data_v[g] != $past(rd_data_v[g])) |-> $past(rd_en_v[g], 2));
  end

endmodule

// File: tb/regfile_2r1w_bench.sv
`timescale 1ns/1ps
module regfile_2r1w_bench;

  localparam int D  = 64;
  localparam int W  = 72;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd0_en = 1'b0, rd1_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd0_data, rd1_data;

  int nchk = 0;
  int nfail = 0;

  // Behavioural reference: memory image, two-deep request history per port.
  logic [W-1:0] mm   [D];
  logic         sv   [2][2];
  logic [W-1:0] sd   [2][2];
  logic [W-1:0] expd [2];

  always #2 clk = ~clk;

  regfile_2r1w #(.DEPTH(D), .WIDTH(W)) u_regfile_2r1w (
    .clk(clk), .rst(rst),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [W-1:0] rnd_word();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[W-1:0];
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  task automatic check_out(input string tag);
    logic [W-1:0] act;
    for (int k = 0; k < 2; k++) begin
      act = (k == 0) ? rd0_data : rd1_data;
      if (sv[k][1]) expd[k] = sd[k][1];
      nchk++;
      if (act !== expd[k]) begin
        nfail++;
        $display("FAIL %s port%0d act=%h exp=%h", tag, k, act, expd[k]);
      end
    end
  endtask

  // One request cycle: check what the last edge produced, then present inputs.
  task automatic cyc(input string tag,
                     input logic e0, input logic [AW-1:0] a0,
                     input logic e1, input logic [AW-1:0] a1,
                     input logic we, input logic [AW-1:0] wa,
                     input logic [W-1:0] wd);
    @(negedge clk);
    check_out(tag);
    rst = 1'b0;
    rd0_en = e0; rd0_addr = a0;
    rd1_en = e1; rd1_addr = a1;
    wr_en = we; wr_addr = wa; wr_data = wd;
    sv[0][1] = sv[0][0]; sd[0][1] = sd[0][0];
    sv[1][1] = sv[1][0]; sd[1][1] = sd[1][0];
    sv[0][0] = e0; sd[0][0] = mm[a0];
    sv[1][0] = e1; sd[1][0] = mm[a1];
    if (we) mm[wa] = wd;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, '0, 1'b0, '0, 1'b0, '0, '0);
  endtask

  // R5: requests presented during reset, including a write, must vanish.
  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        for (int k = 0; k < 2; k++) begin
          sv[k][0] = 1'b0; sv[k][1] = 1'b0; expd[k] = '0;
        end
        check_out("R5");
      end
      rst = 1'b1;
      rd0_en = 1'b1; rd1_en = 1'b1; rd0_addr = 3; rd1_addr = 4;
      wr_en = 1'b1; wr_addr = 3; wr_data = rnd_word();
    end
    for (int k = 0; k < 2; k++) begin
      sv[k][0] = 1'b0; sv[k][1] = 1'b0; expd[k] = '0;
    end
  endtask

  initial begin
    #(200000 * 4);
    nchk++;
    nfail++;
    $display("FAIL R3 watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    for (int k = 0; k < 2; k++) begin
      sv[k][0] = 1'b0; sv[k][1] = 1'b0; expd[k] = '0;
    end

    do_reset(4);                                   // R5 reset state
    idle("R5", 2);

    // Fill every entry; R2 covers entry 0 and entry D-1
    for (int i = 0; i < D; i++)
      cyc("R2", 1'b0, '0, 1'b0, '0, 1'b1, AW'(i), {AW'(i), rnd_word()} >> AW);
    cyc("R2", 1'b1, '0, 1'b1, AW'(D - 1), 1'b0, '0, '0);
    idle("R2", 3);

    // R4: write then read the same entry on both ports in the next cycle
    d = rnd_word();
    cyc("R4", 1'b0, '0, 1'b0, '0, 1'b1, 6'd5, d);
    cyc("R4", 1'b1, 6'd5, 1'b1, 6'd5, 1'b0, '0, '0);
    idle("R4", 3);

    // R1: two different entries in the same cycle, while another is written
    cyc("R1", 1'b1, 6'd10, 1'b1, 6'd40, 1'b1, 6'd20, rnd_word());
    cyc("R1", 1'b1, 6'd20, 1'b1, 6'd10, 1'b0, '0, '0);
    idle("R1", 3);

    // R6: read entry 7, then rewrite it with both ports idle; outputs hold
    cyc("R6", 1'b1, 6'd7, 1'b1, 6'd7, 1'b0, '0, '0);
    cyc("R6", 1'b0, '0, 1'b0, '0, 1'b1, 6'd7, rnd_word());
    cyc("R6", 1'b0, 6'd9, 1'b0, 6'd8, 1'b1, 6'd8, rnd_word());
    idle("R6", 4);

    // R7: address toggles right after the request edge
    cyc("R7", 1'b1, 6'd11, 1'b1, 6'd12, 1'b0, '0, '0);
    cyc("R7", 1'b0, 6'd13, 1'b0, 6'd14, 1'b0, '0, '0);
    idle("R7", 3);

    // R8: disabled write with live address and data
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_out("R8");
      rd0_en = 1'b0; rd1_en = 1'b0;
      wr_en = 1'b0; wr_addr = AW'(30 + i); wr_data = rnd_word();
      sv[0][1] = sv[0][0]; sv[1][1] = sv[1][0];
      sd[0][1] = sd[0][0]; sd[1][1] = sd[1][0];
      sv[0][0] = 1'b0; sv[1][0] = 1'b0;
    end
    cyc("R8", 1'b1, 6'd30, 1'b1, 6'd35, 1'b0, '0, '0);
    idle("R8", 3);

    // R5: reset mid-run with a write to entry 3 held high during reset
    idle("R5", 2);
    do_reset(3);
    cyc("R5", 1'b1, 6'd3, 1'b1, 6'd4, 1'b0, '0, '0);
    idle("R5", 3);

    // R3: mixed random traffic, checked every cycle
    for (int n = 0; n < 3000; n++) begin
      logic e0, e1, we;
      logic [AW-1:0] a0, a1, wa;
      e0 = 1'($urandom); e1 = 1'($urandom); we = 1'($urandom);
      a0 = AW'($urandom_range(D - 1));
      a1 = AW'($urandom_range(D - 1));
      wa = AW'($urandom_range(D - 1));
      if (we && a0 == wa) a0 = a0 ^ AW'(1);
      if (we && a1 == wa) a1 = a1 ^ AW'(1);
      cyc("R3", e0, a0, e1, a1, we, wa, rnd_word());
    end
    idle("R3", 4);

    finish_run();
  end

endmodule